// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the write-side command decoder and read-path selector of a NOR-style flash device. Every bus write is treated as a command byte, taken from the low eight bits of the write data. The decoded command chooses what later bus reads return. The four read sources are:

- array data
- identification words
- a short query table stub
- the status register

The chosen source stays in force until another command changes it. Two writes start a block erase: a setup write, then a confirm write. The confirm write latches the block address and starts a simplified program/erase engine. That engine is a countdown timer working on a small register-backed array, and each block has its own protect flag.

While an erase runs, the controller locks out every command except read-status and suspend. A suspended erase can be resumed with the confirm code. Error flags in the status register are sticky and stay set until a clear-status write removes them. A bus read is registered, so `rdata` carries the result one clock after `rd_en` is sampled.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, reads return array data and status reads 0x80. Codes 0xFF (array), 0x90 (identification), 0x98 (query) and 0x70 (status) each select a read source in one write cycle. `rdata` is updated on the clock edge that samples `rd_en`. Array word i resets to {16'hC0DE, i[7:0], ~i[7:0]}.
- R2: The selected read source persists across any number of reads until another accepted command is written.
- R3: In identification mode, address 0 returns 0x0000003C (maker code), address 1 returns 0x00007A11 (device code), address 2 returns 0x0000C5C5 (burst configuration) and every other address returns 0.
- R4: In query mode, addresses 16, 17 and 18 return 0x51, 0x52 and 0x59, and every other address returns 0.
- R5: Code 0x50 clears status bits 5, 4, 3 and 1 in one write and leaves the read source unchanged.
- R6: Status error bits are sticky. Starting a new erase does not clear them; only 0x50 does.
- R7: Writing 0x20 and then 0xD0 latches the block index (address bits above the word offset) and erases that block. Status bit 7 reads 0 for exactly ERASE_CYCLES cycles, after which every word of the block reads 0xFFFFFFFF and all other words are unchanged. Reads after the setup write return status.
- R8: If the write after 0x20 is not 0xD0, the erase aborts, status bits 5 and 4 are set, no data changes, and reads return status.
- R9: While an erase is busy, only 0x70 and 0xB0 are acted on. Every other code is ignored, and reads keep returning status.
- R10: Confirming an erase on a protected block sets status bits 5 and 1, starts no operation and leaves the block data unchanged.
- R11: Status bit 7 is 0 while the engine is busy and 1 when it is idle or suspended. Bit 6 is 1 only while an erase is suspended.
- R12: 0xB0 suspends a busy erase and freezes its countdown. While suspended, the read-source commands and 0x50 are accepted. 0xD0 resumes the erase, which then completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one command per asserted cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address for reads and for the erase confirm write |
| wdata | input | 32 | Write data; command code in bits 7:0 |
| rdata | output | 32 | Registered read data from the selected source |

## Verification
The hardest state to reach from the ports is a suspended erase with part of its countdown left. Reaching it means a setup write, a confirm write to an unprotected block, and a suspend write landing before the countdown ends. After that, array reads must still show the old data and a resume must finish the erase. The bench reaches this state with a directed sequence and times the busy window by reading status on every cycle. The random phase mixes valid commands, bad confirm codes and erases of protected blocks, so the sticky bits collect errors that later clear writes must remove.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_SIG    = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_SETUP = 2'd1,
    CT_BUSY  = 2'd2,
    CT_SUSP  = 2'd3
  } ctl_state_e;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_SIG     = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ESETUP  = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;

  // status bit positions
  localparam int SR_READY = 7;
  localparam int SR_ESUSP = 6;
  localparam int SR_EERR  = 5;
  localparam int SR_PERR  = 4;
  localparam int SR_VERR  = 3;
  localparam int SR_LERR  = 1;

  localparam logic [7:0] STICKY_MASK = 8'b0011_1010;

  localparam logic [31:0] MAKER_CODE  = 32'h0000_003C;
  localparam logic [31:0] DEVICE_CODE = 32'h0000_7A11;
  localparam logic [31:0] BURST_CFG   = 32'h0000_C5C5;

  // Reset contents of array word idx
  function automatic logic [31:0] init_word(input int unsigned idx);
    logic [7:0] lo;
    lo = 8'(idx);
    return {16'hC0DE, lo, ~lo};
  endfunction

  function automatic logic [31:0] sig_word(input logic [15:0] a);
    case (a)
      16'd0:   return MAKER_CODE;
      16'd1:   return DEVICE_CODE;
      16'd2:   return BURST_CFG;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] query_word(input logic [15:0] a);
    case (a)
      16'd16:  return 32'h0000_0051;
      16'd17:  return 32'h0000_0052;
      16'd18:  return 32'h0000_0059;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] sticky_next(input logic [7:0] cur,
                                             input logic [7:0] set,
                                             input logic       clr);
    if (clr) return cur & ~STICKY_MASK;
    return (cur | set) & STICKY_MASK;
  endfunction

endpackage

// File: rtl/fcmd_pec.sv
module fcmd_pec #(
  parameter int ERASE_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(ERASE_CYCLES);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_i,
  input  logic       clr_i,
  input  logic       busy_i,
  input  logic       susp_i,
  output logic [7:0] sr_o
);
  logic [7:0] sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_next(sticky_q, set_i, clr_i);
  end

  always_comb begin
    sr_o            = sticky_q & STICKY_MASK;
    sr_o[SR_READY]  = !busy_i;
    sr_o[SR_ESUSP]  = susp_i;
  end
endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
  import fcmd_pkg::*;
#(
  parameter int                  NUM_BLOCKS = 4,
  parameter int                  BLK_WORDS  = 8,
  parameter logic [NUM_BLOCKS-1:0] PROT_MASK = 4'b0100
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   erase_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0]          erase_blk_i,
  input  logic [$clog2(NUM_BLOCKS*BLK_WORDS)-1:0] rd_addr_i,
  output logic [31:0]                            rd_data_o,
  output logic                                   rd_blk_prot_o
);
  localparam int NUM_WORDS = NUM_BLOCKS * BLK_WORDS;
  localparam int WORD_W    = $clog2(BLK_WORDS);
  localparam int ADDR_W    = $clog2(NUM_WORDS);

  logic [31:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= init_word(i);
    end else if (erase_i) begin
      for (int w = 0; w < BLK_WORDS; w++)
        mem_q[int'(erase_blk_i) * BLK_WORDS + w] <= 32'hFFFF_FFFF;
    end
  end

  assign rd_data_o     = mem_q[rd_addr_i];
  assign rd_blk_prot_o = PROT_MASK[rd_addr_i[ADDR_W-1:WORD_W]];
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int BLK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [7:0]       cmd_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             blk_prot_i,
  input  logic             done_i,
  output rd_mode_e         mode_o,
  output ctl_state_e       state_o,
  output logic             start_o,
  output logic [BLK_W-1:0] erase_blk_o,
  output logic [7:0]       err_set_o,
  output logic             err_clr_o
);
  rd_mode_e         mode_q, mode_n;
  ctl_state_e       state_q, state_n;
  logic [BLK_W-1:0] blk_q, blk_n;

  function automatic logic is_read_op(input logic [7:0] c);
    return (c == OP_ARRAY) || (c == OP_SIG) || (c == OP_QUERY) || (c == OP_STATUS);
  endfunction

  function automatic rd_mode_e op_mode(input logic [7:0] c);
    case (c)
      OP_SIG:   return MODE_SIG;
      OP_QUERY: return MODE_QUERY;
      OP_ARRAY: return MODE_ARRAY;
      default:  return MODE_STATUS;
    endcase
  endfunction

  always_comb begin
    mode_n    = mode_q;
    state_n   = state_q;
    blk_n     = blk_q;
    start_o   = 1'b0;
    err_set_o = '0;
    err_clr_o = 1'b0;
    case (state_q)
      CT_IDLE: if (wr_en_i) begin
        if (is_read_op(cmd_i)) mode_n = op_mode(cmd_i);
        else if (cmd_i == OP_CLEAR) err_clr_o = 1'b1;
        else if (cmd_i == OP_ESETUP) begin
          state_n = CT_SETUP;
          mode_n  = MODE_STATUS;
        end
      end
      CT_SETUP: if (wr_en_i) begin
        mode_n  = MODE_STATUS;
        state_n = CT_IDLE;
        if (cmd_i != OP_CONFIRM) begin
          err_set_o[SR_EERR] = 1'b1;
          err_set_o[SR_PERR] = 1'b1;
        end else if (blk_prot_i) begin
          err_set_o[SR_EERR] = 1'b1;
          err_set_o[SR_LERR] = 1'b1;
        end else begin
          start_o = 1'b1;
          blk_n   = blk_i;
          state_n = CT_BUSY;
        end
      end
      CT_BUSY: begin
        if (done_i) state_n = CT_IDLE;
        else if (wr_en_i) begin
          if (cmd_i == OP_STATUS) mode_n = MODE_STATUS;
          else if (cmd_i == OP_SUSPEND) begin
            mode_n  = MODE_STATUS;
            state_n = CT_SUSP;
          end
        end
      end
      default: if (wr_en_i) begin // suspended
        if (is_read_op(cmd_i)) mode_n = op_mode(cmd_i);
        else if (cmd_i == OP_CLEAR) err_clr_o = 1'b1;
        else if (cmd_i == OP_CONFIRM) begin
          mode_n  = MODE_STATUS;
          state_n = CT_BUSY;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_ARRAY;
      state_q <= CT_IDLE;
      blk_q   <= '0;
    end else begin
      mode_q  <= mode_n;
      state_q <= state_n;
      blk_q   <= blk_n;
    end
  end

  assign mode_o      = mode_q;
  assign state_o     = state_q;
  assign erase_blk_o = blk_q;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcmd_pkg::*;
#(
  parameter int                    NUM_BLOCKS   = 4,
  parameter int                    BLK_WORDS    = 8,
  parameter int                    ERASE_CYCLES = 24,
  parameter logic [NUM_BLOCKS-1:0] PROT_MASK    = 4'b0100,
  localparam int                   ADDR_W       = $clog2(NUM_BLOCKS * BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int WORD_W = $clog2(BLK_WORDS);

  rd_mode_e         mode;
  ctl_state_e       state;
  logic             busy, susp, setup;
  logic             start, done, blk_prot;
  logic [BLK_W-1:0] erase_blk;
  logic [7:0]       err_set;
  logic             err_clr;
  logic [7:0]       sr;
  logic [31:0]      arr_data;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;
  logic             unused_hi;

  assign unused_hi = ^wdata[31:8];

  fcmd_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .cmd_i(wdata[7:0]),
    .blk_i(addr[ADDR_W-1:WORD_W]), .blk_prot_i(blk_prot),
    .done_i(done),
    .mode_o(mode), .state_o(state), .start_o(start),
    .erase_blk_o(erase_blk), .err_set_o(err_set), .err_clr_o(err_clr)
  );

  assign busy  = (state == CT_BUSY);
  assign susp  = (state == CT_SUSP);
  assign setup = (state == CT_SETUP);

  fcmd_pec #(.ERASE_CYCLES(ERASE_CYCLES)) u_pec (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .run_i(busy), .done_o(done)
  );

  fcmd_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_i(err_set), .clr_i(err_clr),
    .busy_i(busy), .susp_i(susp), .sr_o(sr)
  );

  fcmd_array #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_WORDS(BLK_WORDS), .PROT_MASK(PROT_MASK)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .erase_i(done), .erase_blk_i(erase_blk),
    .rd_addr_i(addr), .rd_data_o(arr_data), .rd_blk_prot_o(blk_prot)
  );

  always_comb begin
    case (mode)
      MODE_ARRAY: rd_mux = arr_data;
      MODE_SIG:   rd_mux = sig_word(16'(addr));
      MODE_QUERY: rd_mux = query_word(16'(addr));
      default:    rd_mux = {24'h0, sr};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
  import fcmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [31:0] wdata,
  input rd_mode_e   mode,
  input ctl_state_e state,
  input logic       busy,
  input logic       setup,
  input logic       start,
  input logic       done,
  input logic       blk_prot,
  input logic [7:0] sr
);
  // R6: an error bit stays set unless a clear command is written
  assert_sticky_erase_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[SR_EERR] && !(wr_en && wdata[7:0] == OP_CLEAR)) |=> sr[SR_EERR]);

  assert_sticky_prot_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[SR_LERR] && !(wr_en && wdata[7:0] == OP_CLEAR)) |=> sr[SR_LERR]);

  // R11: engine start shows busy, completion shows ready
  assert_busy_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sr[SR_READY]);

  assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sr[SR_READY] && !busy));

  // R9: lockout while busy
  assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && wr_en && wdata[7:0] != OP_SUSPEND) |=> (busy && mode == MODE_STATUS));

  // R8: bad confirm aborts
  assert_bad_confirm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && wr_en && wdata[7:0] != OP_CONFIRM)
      |=> (sr[SR_EERR] && sr[SR_PERR] && mode == MODE_STATUS && !busy));

  // R10: protected block never starts the engine
  assert_protected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && wr_en && wdata[7:0] == OP_CONFIRM && blk_prot)
      |=> (sr[SR_EERR] && sr[SR_LERR] && !busy));

  // R5: clear keeps the read source and empties the error bits
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[7:0] == OP_CLEAR && state == CT_IDLE)
      |=> ($stable(mode) && !sr[SR_EERR] && !sr[SR_PERR] && !sr[SR_VERR] && !sr[SR_LERR]));
endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .mode(mode), .state(state), .busy(busy), .setup(setup),
  .start(start), .done(done), .blk_prot(blk_prot), .sr(sr)
);

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
  localparam int NB    = 4;
  localparam int BW    = 8;
  localparam int NW    = NB * BW;
  localparam int ECYC  = 24;
  localparam logic [3:0] PMASK = 4'b0100;
  localparam int AW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  // model state: 0 array, 1 sig, 2 query, 3 status
  int          m_mode;
  logic [7:0]  m_err;
  logic [31:0] m_mem [NW];

  always #4 clk = ~clk;

  flash_cmd_if #(.NUM_BLOCKS(NB), .BLK_WORDS(BW), .ERASE_CYCLES(ECYC),
                 .PROT_MASK(PMASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  function automatic logic [31:0] f_init(int i);
    return 32'hC0DE_0000 | ((i & 255) << 8) | (255 - (i & 255));
  endfunction

  function automatic logic [31:0] f_expect(int a);
    case (m_mode)
      0: return m_mem[a];
      1: return (a == 0) ? 32'h3C : (a == 1) ? 32'h7A11 : (a == 2) ? 32'hC5C5 : 32'h0;
      2: return (a == 16) ? 32'h51 : (a == 17) ? 32'h52 : (a == 18) ? 32'h59 : 32'h0;
      default: return {24'h0, 8'h80 | m_err};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] cmd, int a);
    @(negedge clk);
    wr_en = 1'b1; wdata = {24'h5A5A5A, cmd}; addr = AW'(a);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_chk(string tag, int a);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, f_expect(a));
  endtask

  // model the effect of one accepted command in idle
  task automatic model_cmd(logic [7:0] c);
    case (c)
      8'hFF: m_mode = 0;
      8'h90: m_mode = 1;
      8'h98: m_mode = 2;
      8'h70: m_mode = 3;
      8'h50: m_err = 8'h00;
      default: ;
    endcase
  endtask

  // poll status every cycle after the confirm write, return busy count
  task automatic poll_ready(output int cnt);
    cnt = 0;
    rd_en = 1'b1; addr = '0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (rdata[7]) break;
      cnt++;
    end
    rd_en = 1'b0;
  endtask

  task automatic erase_blk(int b, bit exact);
    int cnt;
    wr(8'h20, b * BW);
    wr(8'hD0, b * BW);
    m_mode = 3;
    if (PMASK[b]) begin
      m_err = m_err | 8'h22;
      rd_chk("R10 protected erase status", 0);
    end else begin
      poll_ready(cnt);
      if (exact) chk("R7 busy window length", 32'(cnt), 32'(ECYC));
      for (int w = 0; w < BW; w++) m_mem[b * BW + w] = 32'hFFFF_FFFF;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) m_mem[i] = f_init(i);
    m_mode = 0; m_err = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 reset array word 3", 3);
    rd_chk("R1 reset array word 29", 29);
    wr(8'h70, 0); model_cmd(8'h70);
    rd_chk("R1 reset status", 0);

    // R3 identification, R2 persistence
    wr(8'h90, 0); model_cmd(8'h90);
    rd_chk("R3 maker code", 0);
    rd_chk("R3 device code", 1);
    rd_chk("R3 burst config", 2);
    rd_chk("R2 ident persists", 7);

    // R4 query
    wr(8'h98, 0); model_cmd(8'h98);
    rd_chk("R4 query 16", 16);
    rd_chk("R4 query 17", 17);
    rd_chk("R4 query 18", 18);
    rd_chk("R4 query other", 5);

    // R8 bad confirm, R5 clear keeps mode
    wr(8'h20, 0); wr(8'hFF, 0);
    m_mode = 3; m_err = m_err | 8'h30;
    rd_chk("R8 bad confirm status", 0);
    wr(8'hFF, 0); model_cmd(8'hFF);
    rd_chk("R8 data unchanged", 0);
    wr(8'h50, 0); model_cmd(8'h50);
    rd_chk("R5 clear keeps array mode", 9);
    wr(8'h70, 0); model_cmd(8'h70);
    rd_chk("R5 status after clear", 0);

    // R10 protected block
    erase_blk(2, 1'b0);
    wr(8'hFF, 0); model_cmd(8'hFF);
    rd_chk("R10 protected data kept", 2 * BW + 3);

    // R6 sticky across a new erase, R7 exact busy window
    erase_blk(0, 1'b1);
    rd_chk("R6 error bits kept after erase", 0);
    wr(8'hFF, 0); model_cmd(8'hFF);
    rd_chk("R7 erased word", 5);
    rd_chk("R7 neighbour untouched", BW + 5);
    wr(8'h50, 0); model_cmd(8'h50);

    // R9 lockout during busy
    wr(8'h20, 3 * BW); wr(8'hD0, 3 * BW); m_mode = 3;
    wr(8'hFF, 0);
    rd(0, v);
    chk("R9 ignored command busy status", v, 32'h0000_0000);
    wr(8'h50, 0);
    wr(8'h70, 0);
    poll_ready(cnt);
    for (int w = 0; w < BW; w++) m_mem[3 * BW + w] = 32'hFFFF_FFFF;
    rd_chk("R9 still status after completion", 0);
    wr(8'hFF, 0); model_cmd(8'hFF);
    rd_chk("R9 block erased", 3 * BW + 7);

    // R12 suspend and resume, R11 bits 7 and 6
    wr(8'h20, BW); wr(8'hD0, BW);
    repeat (5) @(negedge clk);
    wr(8'hB0, 0);
    rd(0, v);
    chk("R11 suspended status", v, 32'h0000_00C0);
    wr(8'hFF, 0);
    rd(BW + 2, v);
    chk("R12 array readable in suspend", v, m_mem[BW + 2]);
    repeat (40) @(negedge clk);
    rd(BW + 2, v);
    chk("R12 countdown frozen", v, m_mem[BW + 2]);
    wr(8'hD0, 0); m_mode = 3;
    rd(0, v);
    chk("R11 busy after resume", v, 32'h0000_0000);
    poll_ready(cnt);
    for (int w = 0; w < BW; w++) m_mem[BW + w] = 32'hFFFF_FFFF;
    rd_chk("R12 ready after resume", 0);
    wr(8'hFF, 0); model_cmd(8'hFF);
    rd_chk("R12 resumed erase done", BW + 2);

    // random phase
    for (int it = 0; it < 500; it++) begin
      int r;
      r = $urandom % 12;
      if (r < 6) begin
        rd_chk("R2 random read", $urandom % NW);
      end else if (r < 10) begin
        logic [7:0] c;
        case ($urandom % 6)
          0: c = 8'hFF; 1: c = 8'h90; 2: c = 8'h98;
          3: c = 8'h70; 4: c = 8'h50; default: c = 8'hB0;
        endcase
        wr(c, $urandom % NW);
        model_cmd(c);
      end else if (r == 10) begin
        logic [7:0] bad;
        bad = ($urandom % 2) ? 8'h70 : 8'h00;
        wr(8'h20, 0); wr(bad, 0);
        m_mode = 3; m_err = m_err | 8'h30;
        rd_chk("R8 random bad confirm", 0);
      end else begin
        erase_blk($urandom % NB, 1'b0);
        rd_chk("R7 random post-erase status", 0);
      end
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule